// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits on the write side of a parallel flash controller. Each accepted write cycle carries an address and a data word. The block recognises the multi-cycle unlock sequences that guard destructive operations. When a sequence completes, it raises a single-cycle request that names the operation and carries the address and data of the write that finished it. A small set of commands needs no unlock and is recognised from one write.

A bypass mode lets a host stream program data without repeating the unlock preamble. Once this mode is entered, every accepted write becomes a program request. Only the reset input leaves the mode. While the operation engine downstream reports busy, the block drops incoming writes without any effect.

The write interface has no back-pressure. A cycle with `wr_valid` high is consumed in that cycle, and it is either decoded or, while `busy` is high, discarded. The request output is a one-cycle pulse with no ready. The engine must take it in the cycle it appears.

Top module: `flash_cmd_decoder`

## Requirements
- R1: Every sequence opens with an unlock pair: data 0xAA at address 0x5555, then data 0x55 at address 0x2AAA. The block compares only the low 16 address bits and the low 8 data bits, so higher address and data bits have no effect on matching.
- R2: After the unlock pair, 0xA0 at 0x5555 makes the next write a program request. Program is `req_op` = 1, and the request carries that fourth write's full address and data.
- R3: After the unlock pair, 0x80 at 0x5555 followed by a second unlock pair makes the sixth write choose the operation. 0x10 at 0x5555 gives chip erase (`req_op` = 2). 0x30 at any address gives sector erase (`req_op` = 3). 0x40 at any address gives sector lock (`req_op` = 4). The request carries the sixth write's address and data.
- R4: After the unlock pair, 0x90 at 0x5555 gives identification entry (`req_op` = 7) and 0xF0 at 0x5555 gives identification exit (`req_op` = 8). A lone 0xF0 at any address, outside a sequence, also gives identification exit.
- R5: Outside a sequence, a lone 0xB0 at any address gives erase suspend (`req_op` = 5). A lone 0x30 gives erase resume (`req_op` = 6), and its request carries the full address, so the plane in bits 19:18 reaches the engine.
- R6: A six-write sequence whose sixth write is BYPASS_CODE (default 0x20) at 0x5555 emits bypass entry (`req_op` = 9). `bypass_mode` goes high in the next cycle. From then on, every accepted write gives a program request with its own address and data, including writes whose data would otherwise be an erase, suspend, resume or unlock code.
- R7: `bypass_mode` stays high until `rst_n` goes low. No write clears it.
- R8: A write presented while `busy` is high produces no request and leaves the sequence position unchanged.
- R9: A write that does not match the expected address and data at any point of a sequence returns the block to idle. It emits no request, and that write is not decoded as a command.
- R10: `req_valid` is high for exactly one cycle, in the cycle after the clock edge that accepted the completing write. Reset clears `req_valid` and `bypass_mode`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; the only exit from bypass mode |
| wr_valid | input | 1 | A write cycle is present this clock |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data; the low 8 bits are the command byte |
| busy | input | 1 | Engine busy; writes are discarded while high |
| req_valid | output | 1 | One-cycle operation request |
| req_op | output | 4 | Operation code: 1 program, 2 chip erase, 3 sector erase, 4 sector lock, 5 suspend, 6 resume, 7 id entry, 8 id exit, 9 bypass entry |
| req_addr | output | ADDR_W | Address of the write that completed the request |
| req_data | output | DATA_W | Data of the write that completed the request |
| bypass_mode | output | 1 | Bypass program mode is active |

## Verification
The bench builds the block with a 20-bit address and a 16-bit data word, and keeps the default bypass code of 0x20. The wide data word means every command can be sent with a non-zero upper byte. This shows that only the low byte is decoded, and that program requests still pass the whole word through. Unlock writes are also sent with non-zero upper address bits, which shows that only the low 16 bits are compared. The wide address also lets resume and sector writes name addresses in the upper planes.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

  typedef enum logic [3:0] {
    OP_NONE         = 4'd0,
    OP_PROGRAM      = 4'd1,
    OP_CHIP_ERASE   = 4'd2,
    OP_SECTOR_ERASE = 4'd3,
    OP_SECTOR_LOCK  = 4'd4,
    OP_SUSPEND      = 4'd5,
    OP_RESUME       = 4'd6,
    OP_ID_ENTER     = 4'd7,
    OP_ID_EXIT      = 4'd8,
    OP_BYPASS       = 4'd9
  } fcd_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_UNL1,
    ST_UNL2,
    ST_PROG,
    ST_EXT1,
    ST_EXT2,
    ST_EXT3
  } fcd_state_e;

  localparam int CMD_W     = 8;
  localparam int NUM_CODES = 11;
  localparam int CI_AA  = 0;
  localparam int CI_55  = 1;
  localparam int CI_A0  = 2;
  localparam int CI_80  = 3;
  localparam int CI_90  = 4;
  localparam int CI_F0  = 5;
  localparam int CI_10  = 6;
  localparam int CI_30  = 7;
  localparam int CI_40  = 8;
  localparam int CI_B0  = 9;
  localparam int CI_BYP = 10;

  function automatic logic [CMD_W-1:0] code_of(input int idx, input logic [CMD_W-1:0] byp);
    case (idx)
      CI_AA:   return 8'hAA;
      CI_55:   return 8'h55;
      CI_A0:   return 8'hA0;
      CI_80:   return 8'h80;
      CI_90:   return 8'h90;
      CI_F0:   return 8'hF0;
      CI_10:   return 8'h10;
      CI_30:   return 8'h30;
      CI_40:   return 8'h40;
      CI_B0:   return 8'hB0;
      default: return byp;
    endcase
  endfunction

  typedef struct packed {
    logic                 key1;
    logic                 key2;
    logic [NUM_CODES-1:0] hit;
  } fcd_cls_t;

endpackage

// File: rtl/fcd_classify.sv
module fcd_classify
  import fcd_pkg::*;
#(
  parameter int               ADDR_W      = 20,
  parameter int               DATA_W      = 8,
  parameter int               KEY_W       = 16,
  parameter logic [KEY_W-1:0] KEY1_ADDR   = 16'h5555,
  parameter logic [KEY_W-1:0] KEY2_ADDR   = 16'h2AAA,
  parameter logic [7:0]       BYPASS_CODE = 8'h20
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output fcd_cls_t          cls
);

  logic [CMD_W-1:0]     cmd;
  logic [KEY_W-1:0]     key_part;
  logic [NUM_CODES-1:0] hit;

  assign cmd      = data[CMD_W-1:0];
  assign key_part = addr[KEY_W-1:0];

  generate
    for (genvar gi = 0; gi < NUM_CODES; gi++) begin : g_code
      assign hit[gi] = (cmd == code_of(gi, BYPASS_CODE));
    end
  endgenerate

  always_comb begin
    cls.key1 = (key_part == KEY1_ADDR);
    cls.key2 = (key_part == KEY2_ADDR);
    cls.hit  = hit;
  end

endmodule

// File: rtl/fcd_seq.sv
module fcd_seq
  import fcd_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     take,
  input  fcd_cls_t cls,
  output fcd_op_e  op_now,
  output logic     bypass_mode
);

  fcd_state_e st_q, st_d;
  logic       byp_d;
  logic       unl_a, unl_b, at_k1;

  assign at_k1 = cls.key1;
  assign unl_a = cls.key1 && cls.hit[CI_AA];
  assign unl_b = cls.key2 && cls.hit[CI_55];

  always_comb begin
    st_d   = st_q;
    byp_d  = bypass_mode;
    op_now = OP_NONE;
    if (take) begin
      st_d = ST_IDLE;
      if (bypass_mode) begin
        op_now = OP_PROGRAM;
      end else begin
        case (st_q)
          ST_IDLE: begin
            if (unl_a)                st_d   = ST_UNL1;
            else if (cls.hit[CI_B0])  op_now = OP_SUSPEND;
            else if (cls.hit[CI_30])  op_now = OP_RESUME;
            else if (cls.hit[CI_F0])  op_now = OP_ID_EXIT;
          end
          ST_UNL1: if (unl_b) st_d = ST_UNL2;
          ST_UNL2: begin
            if (at_k1) begin
              if (cls.hit[CI_A0])      st_d   = ST_PROG;
              else if (cls.hit[CI_80]) st_d   = ST_EXT1;
              else if (cls.hit[CI_90]) op_now = OP_ID_ENTER;
              else if (cls.hit[CI_F0]) op_now = OP_ID_EXIT;
            end
          end
          ST_PROG: op_now = OP_PROGRAM;
          ST_EXT1: if (unl_a) st_d = ST_EXT2;
          ST_EXT2: if (unl_b) st_d = ST_EXT3;
          ST_EXT3: begin
            if (at_k1 && cls.hit[CI_10])       op_now = OP_CHIP_ERASE;
            else if (cls.hit[CI_30])           op_now = OP_SECTOR_ERASE;
            else if (cls.hit[CI_40])           op_now = OP_SECTOR_LOCK;
            else if (at_k1 && cls.hit[CI_BYP]) begin
              op_now = OP_BYPASS;
              byp_d  = 1'b1;
            end
          end
          default: st_d = ST_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      bypass_mode <= 1'b0;
    end else begin
      st_q        <= st_d;
      bypass_mode <= byp_d;
    end
  end

endmodule

// File: rtl/fcd_req_reg.sv
module fcd_req_reg
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  fcd_op_e           op_now,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic              req_valid,
  output logic [3:0]        req_op,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_data
);

  logic fire;
  assign fire = (op_now != OP_NONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_valid <= 1'b0;
      req_op    <= OP_NONE;
      req_addr  <= '0;
      req_data  <= '0;
    end else begin
      req_valid <= fire;
      if (fire) begin
        req_op   <= op_now;
        req_addr <= addr;
        req_data <= data;
      end
    end
  end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int         ADDR_W      = 20,
  parameter int         DATA_W      = 8,
  parameter logic [7:0] BYPASS_CODE = 8'h20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              busy,
  output logic              req_valid,
  output logic [3:0]        req_op,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_data,
  output logic              bypass_mode
);

  localparam int KEY_W = 16;

  fcd_cls_t cls;
  fcd_op_e  op_now;
  logic     take;

  assign take = wr_valid && !busy;

  fcd_classify #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_W(KEY_W),
    .KEY1_ADDR(16'h5555), .KEY2_ADDR(16'h2AAA), .BYPASS_CODE(BYPASS_CODE)
  ) u_classify (
    .addr(wr_addr), .data(wr_data), .cls(cls)
  );

  fcd_seq u_seq (
    .clk(clk), .rst_n(rst_n), .take(take), .cls(cls),
    .op_now(op_now), .bypass_mode(bypass_mode)
  );

  fcd_req_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_req (
    .clk(clk), .rst_n(rst_n), .op_now(op_now), .addr(wr_addr), .data(wr_data),
    .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr), .req_data(req_data)
  );

endmodule

// File: rtl/fcd_checker.sv
module fcd_checker
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              busy,
  input logic              req_valid,
  input logic [3:0]        req_op,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] req_data,
  input logic              bypass_mode
);

  AST_REQ_FROM_ACCEPTED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> $past(wr_valid && !busy)); // R10

  AST_BUSY_WRITE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && busy) |=> !req_valid); // R8

  AST_BYPASS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    bypass_mode |=> bypass_mode); // R7

  AST_BYPASS_ALL_PROGRAM: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass_mode && wr_valid && !busy) |=> (req_valid && req_op == OP_PROGRAM)); // R6

  AST_BYPASS_ENTRY_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bypass_mode) |-> (req_valid && req_op == OP_BYPASS)); // R6

  AST_PROGRAM_PAYLOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == OP_PROGRAM) |->
      (req_addr == $past(wr_addr) && req_data == $past(wr_data))); // R2

  AST_OP_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_op != OP_NONE && req_op <= OP_BYPASS)); // R10

endmodule

bind flash_cmd_decoder fcd_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fcd_checker (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
  .busy(busy), .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
  .req_data(req_data), .bypass_mode(bypass_mode)
);

// File: tb/flash_cmd_decoder_bench.sv
module flash_cmd_decoder_bench;

  localparam int AW = 20;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_valid = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          busy = 1'b0;
  logic          req_valid;
  logic [3:0]    req_op;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_data;
  logic          bypass_mode;

  int n_chk = 0;
  int n_fail = 0;

  logic [3:0]    q_op[$];
  logic [AW-1:0] q_addr[$];
  logic [DW-1:0] q_data[$];
  string         q_tag[$];
  string         cur_tag = "R10";

  always #5 clk = ~clk;

  flash_cmd_decoder #(.ADDR_W(AW), .DATA_W(DW), .BYPASS_CODE(8'h20)) u_flash_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
    .req_data(req_data), .bypass_mode(bypass_mode)
  );

  // Monitor: pops the scoreboard whenever a request appears.
  always @(negedge clk) begin
    if (rst_n && req_valid) begin
      n_chk++;
      if (q_op.size() == 0) begin
        n_fail++;
        $display("FAIL %s unexpected request: op=%0d addr=%h data=%h expected none",
                 cur_tag, req_op, req_addr, req_data);
      end else begin
        automatic logic [3:0]    e_op   = q_op.pop_front();
        automatic logic [AW-1:0] e_addr = q_addr.pop_front();
        automatic logic [DW-1:0] e_data = q_data.pop_front();
        automatic string         e_tag  = q_tag.pop_front();
        if (req_op !== e_op || req_addr !== e_addr || req_data !== e_data) begin
          n_fail++;
          $display("FAIL %s request: actual op=%0d addr=%h data=%h expected op=%0d addr=%h data=%h",
                   e_tag, req_op, req_addr, req_data, e_op, e_addr, e_data);
        end
      end
    end
  end

  task automatic expect_req(input logic [3:0] op, input logic [AW-1:0] a,
                            input logic [DW-1:0] d, input string tag);
    q_op.push_back(op); q_addr.push_back(a); q_data.push_back(d); q_tag.push_back(tag);
  endtask

  // Called at a negedge; presents one write for one clock.
  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic bz = 1'b0);
    wr_valid = 1'b1; wr_addr = a; wr_data = d; busy = bz;
    @(negedge clk);
    wr_valid = 1'b0; busy = 1'b0;
  endtask

  task automatic unlock();
    wr(20'hF5555, 16'h77AA);   // upper address and data bits are don't-care (R1)
    wr(20'h32AAA, 16'h1255);
  endtask

  task automatic six_prefix();
    unlock();
    wr(20'h05555, 16'h0080);
    unlock();
  endtask

  task automatic drained(input string tag);
    repeat (2) @(negedge clk);
    n_chk++;
    if (q_op.size() != 0) begin
      n_fail++;
      $display("FAIL %s pending requests: actual %0d missing expected 0", tag, q_op.size());
      q_op.delete(); q_addr.delete(); q_data.delete(); q_tag.delete();
    end
  endtask

  task automatic check_bit(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_bit(req_valid, 1'b0, "R10 reset req_valid");
    check_bit(bypass_mode, 1'b0, "R10 reset bypass_mode");
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2: program, high bits of unlock writes ignored
    cur_tag = "R2";
    unlock();
    wr(20'hA5555, 16'hFFA0);
    expect_req(4'd1, 20'h81234, 16'hBE3C, "R2 program");
    wr(20'h81234, 16'hBE3C);
    drained("R2");

    // R3: chip erase, sector erase, sector lock
    cur_tag = "R3";
    six_prefix();
    expect_req(4'd2, 20'h05555, 16'h0010, "R3 chip erase");
    wr(20'h05555, 16'h0010);
    six_prefix();
    expect_req(4'd3, 20'h42000, 16'h5530, "R3 sector erase");
    wr(20'h42000, 16'h5530);
    six_prefix();
    expect_req(4'd4, 20'h01000, 16'h0040, "R3 sector lock");
    wr(20'h01000, 16'h0040);
    drained("R3");

    // R4: id entry/exit
    cur_tag = "R4";
    unlock();
    expect_req(4'd7, 20'h05555, 16'h0090, "R4 id entry");
    wr(20'h05555, 16'h0090);
    unlock();
    expect_req(4'd8, 20'h05555, 16'h00F0, "R4 id exit sequence");
    wr(20'h05555, 16'h00F0);
    expect_req(4'd8, 20'h03333, 16'hAAF0, "R4 id exit single");
    wr(20'h03333, 16'hAAF0);
    drained("R4");

    // R5: suspend/resume, plane bits carried
    cur_tag = "R5";
    expect_req(4'd5, 20'h00777, 16'h00B0, "R5 suspend");
    wr(20'h00777, 16'h00B0);
    expect_req(4'd6, 20'hC0000, 16'h0030, "R5 resume plane");
    wr(20'hC0000, 16'h0030);
    drained("R5");

    // R9: mismatches return to idle, no request; mismatching write not decoded
    cur_tag = "R9";
    wr(20'h05555, 16'h00AA);
    wr(20'h02AAA, 16'h0056);
    wr(20'h05555, 16'h00A0);
    wr(20'h01111, 16'h0022);
    unlock();
    wr(20'h01555, 16'h00A0);
    wr(20'h01112, 16'h0023);
    wr(20'h05555, 16'h00AA);
    wr(20'h02AAA, 16'h00B0);   // suspend code mid-sequence is not decoded
    six_prefix();
    wr(20'h01234, 16'h0020);   // bypass code off key address
    six_prefix();
    wr(20'h01234, 16'h0010);   // chip erase code off key address
    drained("R9");
    check_bit(bypass_mode, 1'b0, "R9 bypass not entered");

    // R8: busy write mid-sequence ignored, sequence continues
    cur_tag = "R8";
    unlock();
    wr(20'h00000, 16'h0012, 1'b1);
    wr(20'h00777, 16'h00B0, 1'b1);
    wr(20'h05555, 16'h00A0);
    expect_req(4'd2 - 4'd1, 20'h00042, 16'h0099, "R8 program after busy writes");
    wr(20'h00042, 16'h0099);
    drained("R8");

    // R6: bypass entry and reinterpretation
    cur_tag = "R6";
    six_prefix();
    expect_req(4'd9, 20'h05555, 16'h0020, "R6 bypass entry");
    wr(20'h05555, 16'h0020);
    check_bit(bypass_mode, 1'b1, "R6 bypass_mode high");
    expect_req(4'd1, 20'h10000, 16'h0030, "R6 30 as program");
    wr(20'h10000, 16'h0030);
    expect_req(4'd1, 20'h00777, 16'h00B0, "R6 B0 as program");
    wr(20'h00777, 16'h00B0);
    expect_req(4'd1, 20'h05555, 16'h00AA, "R6 AA as program");
    wr(20'h05555, 16'h00AA);
    expect_req(4'd1, 20'h02AAA, 16'h0055, "R6 55 as program");
    wr(20'h02AAA, 16'h0055);
    cur_tag = "R8";
    wr(20'h00001, 16'h0001, 1'b1);
    drained("R6");
    check_bit(bypass_mode, 1'b1, "R7 bypass held after writes");

    // R7: reset exits bypass
    cur_tag = "R7";
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check_bit(bypass_mode, 1'b0, "R7 reset clears bypass");
    rst_n = 1'b1;
    @(negedge clk);
    expect_req(4'd5, 20'h00100, 16'h00B0, "R7 suspend decoded after reset");
    wr(20'h00100, 16'h00B0);
    drained("R7");

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule